// File: doc/BRIEF.md
# ISA-Style Bus Cycle Sequencer

This block turns one processor-side access into a bus cycle counted in processor T-states. A request carries an address, a read/write flag, a size code and a flag that says whether the target is an on-chip peripheral or something on the external bus. The sequencer accepts the request when it is idle, raises `busy`, and walks through an address phase (T1), a command phase (T2) and a completion phase (T3). A one-clock `done` pulse in T3 hands the result back, with read data alongside.

On-chip peripheral cycles always take three clocks and ignore every stretching input. External cycles drive ISA-like strobes directly: an address-latch pulse in T1, an active-low read or write command through T2, and release in T3. T2 repeats once for each programmed wait state from chip-select logic. It also repeats for as long as the addressed device holds its ready line low. A debug mirror mode copies each on-chip peripheral access onto the external pins in the same clocks, so that an analyser can capture it. Its timing stays fixed at three clocks.

Top module: `busCycleSeq`

## Requirements
- R1: After reset, `busy` and `done` are low, `extRdN` and `extWrN` are high, and `extAle`, `extDataOe`, `intSel` and `rdData` are zero.
- R2: A request seen with `reqValid` high while `busy` is low is accepted at that clock edge. T1 is the next clock. `busy` is high from T1 through T3 inclusive.
- R3: An internal access lasts exactly three clocks (T1, T2, T3), whatever `waitCount` and `extReady` hold. `intSel` is high only in T2, with `intWrite` high in that clock for writes. `intAddr` holds the request address from T1 to T3.
- R4: A visible external cycle pulses `extAle` high in T1. It holds `extRdN` (read) or `extWrN` (write) low in every T2 clock and high in T3. The two commands are never low together. `extAddr` carries the address from T1 to T3 and is zero otherwise. With no waits and ready high, the cycle is three clocks.
- R5: `waitCount`, sampled at acceptance, adds that many extra T2 clocks to an external cycle.
- R6: `extReady` is sampled at the end of each T2 of an external cycle once the wait count has run out. A low sample adds one more T2.
- R7: `done` is high for exactly one clock, in T3. `rdData` then holds the data sampled at the end of the last T2: `extDataIn` for external reads, `intRdata` for internal reads. It keeps that value until the next read completes. Writes leave it unchanged.
- R8: `reqValid` while `busy` is high is ignored. It has no effect on the running cycle, and nothing is queued.
- R9: With `mirrorEn` high at acceptance, an internal access also drives `extAle`, the command strobes, `extAddr` and `extByteEn` in the same clocks as an external cycle, still in three clocks. Without it, the external pins stay inactive during internal accesses.
- R10: `reqSize` 0 selects one byte lane, 1 selects two and 2 or 3 selects all four. The lanes form the naturally aligned group containing `reqAddr[1:0]`, shown on `extByteEn` (bit n = lane n) from T1 to T3 of visible cycles.
- R11: For visible write cycles, `extDataOe` is high and `extDataOut` equals the write data from T2 to T3. Otherwise both are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock; one period is one T-state |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Access request |
| reqAddr | input | 24 | Access address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 2 | Size code (0 byte, 1 two bytes, 2/3 four bytes) |
| reqInternal | input | 1 | 1 = on-chip peripheral target |
| reqWdata | input | 32 | Write data |
| waitCount | input | 4 | Programmed wait states from chip-select logic |
| mirrorEn | input | 1 | Debug mirror of internal accesses |
| busy | output | 1 | Cycle in progress, new requests ignored |
| done | output | 1 | One-clock completion pulse |
| rdData | output | 32 | Captured read data |
| extAle | output | 1 | External address latch pulse (T1) |
| extRdN | output | 1 | External read command, active low |
| extWrN | output | 1 | External write command, active low |
| extAddr | output | 24 | External address |
| extByteEn | output | 4 | External byte lane enables |
| extDataOut | output | 32 | External write data |
| extDataOe | output | 1 | External data drive enable |
| extDataIn | input | 32 | External read data |
| extReady | input | 1 | External ready feedback |
| intSel | output | 1 | On-chip peripheral select (T2) |
| intWrite | output | 1 | On-chip peripheral write strobe |
| intAddr | output | 24 | On-chip peripheral address |
| intWdata | output | 32 | On-chip peripheral write data |
| intRdata | input | 32 | On-chip peripheral read data |

## Verification
Internal and external reads and writes with zero wait states separate the fixed three-clock path from the stretchable one. Programmed wait counts with ready held high, and ready held low once the count is spent, show whether the two stretch sources add up correctly. Mirrored internal accesses with ready low and a large wait count show that the debug copy has the same timing as the internal access while still driving the pins. Long random runs mix sizes, misaligned addresses and requests asserted while busy, with read data changing every clock, which exposes capture taken one edge early or late.

// File: rtl/busSeqPkg.sv
package busSeqPkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_T1   = 2'd1,
    PH_T2   = 2'd2,
    PH_T3   = 2'd3
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // request accepted this edge
    logic latchRead;  // last T2 ends this edge
    logic inAddr;     // T1
    logic inCmd;      // T2 (and its repeats)
    logic inEnd;      // T3
  } seqStrobe_t;

endpackage

// File: rtl/busSeqCtrl.sv
module busSeqCtrl
  import busSeqPkg::*;
#(
  parameter int WW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic [WW-1:0] waitCount,
  input  logic          extReady,
  input  logic          curInternal,
  output logic          busy,
  output logic          done,
  output seqStrobe_t    strobe
);

  phase_e        phase, phaseNext;
  logic [WW-1:0] waitsLeft;
  logic          accept;
  logic          leaveCmd;

  assign accept   = (phase == PH_IDLE) && reqValid;
  assign leaveCmd = (phase == PH_T2) &&
                    (curInternal || ((waitsLeft == '0) && extReady));

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE: if (reqValid) phaseNext = PH_T1;
      PH_T1:   phaseNext = PH_T2;
      PH_T2:   if (leaveCmd) phaseNext = PH_T3;
      PH_T3:   phaseNext = PH_IDLE;
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      waitsLeft <= '0;
    end else begin
      phase <= phaseNext;
      if (accept)
        waitsLeft <= waitCount;
      else if (phase == PH_T2 && !curInternal && waitsLeft != '0)
        waitsLeft <= waitsLeft - 1'b1;
    end
  end

  assign busy             = (phase != PH_IDLE);
  assign done             = (phase == PH_T3);
  assign strobe.capture   = accept;
  assign strobe.latchRead = leaveCmd;
  assign strobe.inAddr    = (phase == PH_T1);
  assign strobe.inCmd     = (phase == PH_T2);
  assign strobe.inEnd     = (phase == PH_T3);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7

  AST_ADDR_TO_CMD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.inAddr |=> strobe.inCmd); // R4

  AST_INT_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.inCmd && curInternal) |=> strobe.inEnd); // R3

  AST_WAIT_STRETCH: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.inCmd && !curInternal && waitsLeft != '0) |=> strobe.inCmd); // R5

  AST_READY_STRETCH: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.inCmd && !curInternal && !extReady) |=> strobe.inCmd); // R6

endmodule

// File: rtl/busSeqDatapath.sv
module busSeqDatapath
  import busSeqPkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  seqStrobe_t      strobe,
  input  logic [AW-1:0]   reqAddr,
  input  logic            reqWrite,
  input  logic [1:0]      reqSize,
  input  logic            reqInternal,
  input  logic [DW-1:0]   reqWdata,
  input  logic            mirrorEn,
  input  logic [DW-1:0]   extDataIn,
  input  logic [DW-1:0]   intRdata,
  output logic            curInternal,
  output logic [DW-1:0]   rdData,
  output logic            extAle,
  output logic            extRdN,
  output logic            extWrN,
  output logic [AW-1:0]   extAddr,
  output logic [DW/8-1:0] extByteEn,
  output logic [DW-1:0]   extDataOut,
  output logic            extDataOe,
  output logic            intSel,
  output logic            intWrite,
  output logic [AW-1:0]   intAddr,
  output logic [DW-1:0]   intWdata
);

  localparam int LANES  = DW / 8;
  localparam int OFFW   = $clog2(LANES);
  localparam int MAXLOG = OFFW;

  logic [AW-1:0]    addrReg;
  logic [DW-1:0]    dataReg;
  logic [LANES-1:0] laneReg;
  logic [LANES-1:0] laneNext;
  logic             writeReg;
  logic             visReg;
  logic             active;
  logic             cmdPhase;

  // byte lanes: aligned group of 2**sizeLog lanes holding the low address
  always_comb begin
    int sizeLog;
    int offs;
    sizeLog = (int'(reqSize) > MAXLOG) ? MAXLOG : int'(reqSize);
    offs    = int'(reqAddr[OFFW-1:0]);
    for (int i = 0; i < LANES; i++)
      laneNext[i] = ((i >> sizeLog) == (offs >> sizeLog));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg     <= '0;
      dataReg     <= '0;
      laneReg     <= '0;
      writeReg    <= 1'b0;
      curInternal <= 1'b0;
      visReg      <= 1'b0;
      rdData      <= '0;
    end else begin
      if (strobe.capture) begin
        addrReg     <= reqAddr;
        dataReg     <= reqWdata;
        laneReg     <= laneNext;
        writeReg    <= reqWrite;
        curInternal <= reqInternal;
        visReg      <= !reqInternal || mirrorEn;
      end
      if (strobe.latchRead && !writeReg)
        rdData <= curInternal ? intRdata : extDataIn;
    end
  end

  assign active   = strobe.inAddr | strobe.inCmd | strobe.inEnd;
  assign cmdPhase = strobe.inCmd | strobe.inEnd;

  // external pins
  assign extAle     = visReg && strobe.inAddr;
  assign extRdN     = !(visReg && strobe.inCmd && !writeReg);
  assign extWrN     = !(visReg && strobe.inCmd && writeReg);
  assign extAddr    = (visReg && active) ? addrReg : '0;
  assign extByteEn  = (visReg && active) ? laneReg : '0;
  assign extDataOe  = visReg && writeReg && cmdPhase;
  assign extDataOut = extDataOe ? dataReg : '0;

  // on-chip peripheral side
  assign intSel   = curInternal && strobe.inCmd;
  assign intWrite = intSel && writeReg;
  assign intAddr  = (curInternal && active) ? addrReg : '0;
  assign intWdata = intWrite ? dataReg : '0;

  AST_CMD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(!extRdN && !extWrN)); // R4

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (active && !strobe.inEnd) |=> ($stable(addrReg) && $stable(writeReg))); // R8

  AST_HIDDEN_INTERNAL: assert property (@(posedge clk) disable iff (!rstN)
    (active && curInternal && !visReg) |-> (extRdN && extWrN && !extAle && !extDataOe)); // R9

  AST_LANES_PRESENT: assert property (@(posedge clk) disable iff (!rstN)
    (visReg && active) |-> (extByteEn != '0)); // R10

endmodule

// File: rtl/busCycleSeq.sv
module busCycleSeq
  import busSeqPkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 32,
  parameter int WW = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic [AW-1:0]   reqAddr,
  input  logic            reqWrite,
  input  logic [1:0]      reqSize,
  input  logic            reqInternal,
  input  logic [DW-1:0]   reqWdata,
  input  logic [WW-1:0]   waitCount,
  input  logic            mirrorEn,
  output logic            busy,
  output logic            done,
  output logic [DW-1:0]   rdData,
  output logic            extAle,
  output logic            extRdN,
  output logic            extWrN,
  output logic [AW-1:0]   extAddr,
  output logic [DW/8-1:0] extByteEn,
  output logic [DW-1:0]   extDataOut,
  output logic            extDataOe,
  input  logic [DW-1:0]   extDataIn,
  input  logic            extReady,
  output logic            intSel,
  output logic            intWrite,
  output logic [AW-1:0]   intAddr,
  output logic [DW-1:0]   intWdata,
  input  logic [DW-1:0]   intRdata
);

  seqStrobe_t strobe;
  logic       curInternal;

  busSeqCtrl #(.WW(WW)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .waitCount  (waitCount),
    .extReady   (extReady),
    .curInternal(curInternal),
    .busy       (busy),
    .done       (done),
    .strobe     (strobe)
  );

  busSeqDatapath #(.AW(AW), .DW(DW)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqAddr    (reqAddr),
    .reqWrite   (reqWrite),
    .reqSize    (reqSize),
    .reqInternal(reqInternal),
    .reqWdata   (reqWdata),
    .mirrorEn   (mirrorEn),
    .extDataIn  (extDataIn),
    .intRdata   (intRdata),
    .curInternal(curInternal),
    .rdData     (rdData),
    .extAle     (extAle),
    .extRdN     (extRdN),
    .extWrN     (extWrN),
    .extAddr    (extAddr),
    .extByteEn  (extByteEn),
    .extDataOut (extDataOut),
    .extDataOe  (extDataOe),
    .intSel     (intSel),
    .intWrite   (intWrite),
    .intAddr    (intAddr),
    .intWdata   (intWdata)
  );

endmodule

// File: tb/busCycleSeq_tb.sv
module busCycleSeq_tb;

  localparam int AW = 24;
  localparam int DW = 32;
  localparam int WW = 4;
  localparam int LANES = DW / 8;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            reqValid = 1'b0;
  logic [AW-1:0]   reqAddr = '0;
  logic            reqWrite = 1'b0;
  logic [1:0]      reqSize = '0;
  logic            reqInternal = 1'b0;
  logic [DW-1:0]   reqWdata = '0;
  logic [WW-1:0]   waitCount = '0;
  logic            mirrorEn = 1'b0;
  logic [DW-1:0]   extDataIn = '0;
  logic            extReady = 1'b1;
  logic [DW-1:0]   intRdata = '0;
  logic            busy, done, extAle, extRdN, extWrN, extDataOe, intSel, intWrite;
  logic [DW-1:0]   rdData, extDataOut, intWdata;
  logic [AW-1:0]   extAddr, intAddr;
  logic [LANES-1:0] extByteEn;

  int vectors = 0;
  int fails = 0;
  bit running = 1'b0;

  busCycleSeq #(.AW(AW), .DW(DW), .WW(WW)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqSize(reqSize), .reqInternal(reqInternal),
    .reqWdata(reqWdata), .waitCount(waitCount), .mirrorEn(mirrorEn),
    .busy(busy), .done(done), .rdData(rdData), .extAle(extAle),
    .extRdN(extRdN), .extWrN(extWrN), .extAddr(extAddr), .extByteEn(extByteEn),
    .extDataOut(extDataOut), .extDataOe(extDataOe), .extDataIn(extDataIn),
    .extReady(extReady), .intSel(intSel), .intWrite(intWrite),
    .intAddr(intAddr), .intWdata(intWdata), .intRdata(intRdata)
  );

  always #2 clk = ~clk;  // 250 MHz

  // behavioural reference model
  int          mPhase = 0;   // 0 idle, 1 address, 2 command, 3 end
  int          mWaits = 0;
  bit          mInt = 0, mVis = 0, mWr = 0;
  logic [AW-1:0] mAddr = '0;
  logic [DW-1:0] mData = '0;
  logic [DW-1:0] mRd = '0;
  logic [LANES-1:0] mLanes = '0;

  function automatic logic [LANES-1:0] laneMask(input logic [AW-1:0] a, input logic [1:0] s);
    int bytes, base;
    logic [LANES-1:0] m;
    bytes = (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    base  = (int'(a) % LANES) / bytes * bytes;
    m = '0;
    for (int k = 0; k < bytes; k++) m[base + k] = 1'b1;
    return m;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase = 0; mWaits = 0; mInt = 0; mVis = 0; mWr = 0;
      mAddr = '0; mData = '0; mRd = '0; mLanes = '0;
    end else begin
      case (mPhase)
        0: if (reqValid) begin
             mAddr = reqAddr; mData = reqWdata; mWr = reqWrite; mInt = reqInternal;
             mVis = !reqInternal || mirrorEn; mWaits = int'(waitCount);
             mLanes = laneMask(reqAddr, reqSize); mPhase = 1;
           end
        1: mPhase = 2;
        2: if (mInt) begin
             if (!mWr) mRd = intRdata;
             mPhase = 3;
           end else if (mWaits > 0) mWaits = mWaits - 1;
           else if (extReady) begin
             if (!mWr) mRd = extDataIn;
             mPhase = 3;
           end
        default: mPhase = 0;
      endcase
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (running && rstN) begin
      bit act, cmd;
      act = (mPhase != 0);
      cmd = (mPhase == 2);
      chk("R2/R8", "busy", 64'(busy), 64'(act));
      chk("R7 R5 R6", "done", 64'(done), 64'(mPhase == 3));
      chk("R7", "rdData", 64'(rdData), 64'(mRd));
      chk("R4/R9", "extAle", 64'(extAle), 64'(mVis && mPhase == 1));
      chk("R4", "extRdN", 64'(extRdN), 64'(!(mVis && cmd && !mWr)));
      chk("R4", "extWrN", 64'(extWrN), 64'(!(mVis && cmd && mWr)));
      chk("R9", "extAddr", 64'(extAddr), 64'((mVis && act) ? mAddr : '0));
      chk("R10", "extByteEn", 64'(extByteEn), 64'((mVis && act) ? mLanes : '0));
      chk("R11", "extDataOe", 64'(extDataOe), 64'(mVis && mWr && mPhase >= 2));
      chk("R11", "extDataOut", 64'(extDataOut), 64'((mVis && mWr && mPhase >= 2) ? mData : '0));
      chk("R3", "intSel", 64'(intSel), 64'(mInt && cmd));
      chk("R3", "intWrite", 64'(intWrite), 64'(mInt && cmd && mWr));
      chk("R3", "intAddr", 64'(intAddr), 64'((mInt && act) ? mAddr : '0));
      chk("R3", "intWdata", 64'(intWdata), 64'((mInt && cmd && mWr) ? mData : '0));
    end
  end

  // read data changes every clock so a capture edge off by one is seen
  always @(negedge clk) begin
    extDataIn <= $urandom;
    intRdata  <= $urandom;
  end

  // one access; ready held low for readyLow clocks after T1
  task automatic runReq(input bit isInt, input bit wr, input logic [1:0] sz,
                        input logic [AW-1:0] a, input int waits, input bit mir,
                        input int readyLow, input bit pokeBusy);
    int guard;
    @(negedge clk);
    reqValid = 1'b1; reqInternal = isInt; reqWrite = wr; reqSize = sz;
    reqAddr = a; reqWdata = $urandom; waitCount = WW'(waits); mirrorEn = mir;
    extReady = 1'b1;
    @(negedge clk);
    reqValid = pokeBusy;  // R8: request while busy must be ignored
    reqAddr = ~a; reqWrite = !wr; reqInternal = !isInt; waitCount = '1;
    guard = 0;
    while (busy && guard < 100) begin
      extReady = (guard < readyLow) ? 1'b0 : 1'b1;
      @(negedge clk);
      guard++;
    end
    reqValid = 1'b0;
    extReady = 1'b1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "busy", 64'(busy), 64'd0);
    chk("R1", "done", 64'(done), 64'd0);
    chk("R1", "extRdN", 64'(extRdN), 64'd1);
    chk("R1", "extWrN", 64'(extWrN), 64'd1);
    chk("R1", "extAle", 64'(extAle), 64'd0);
    chk("R1", "extDataOe", 64'(extDataOe), 64'd0);
    chk("R1", "intSel", 64'(intSel), 64'd0);
    chk("R1", "rdData", 64'(rdData), 64'd0);
    rstN = 1'b1;
    running = 1'b1;
    @(negedge clk);

    // R3: internal, fixed length, stretch inputs ignored
    runReq(1, 0, 2'd2, 24'h000104, 0, 0, 0, 0);
    runReq(1, 1, 2'd0, 24'h000203, 9, 0, 5, 0);
    // R4: external, no waits
    runReq(0, 0, 2'd2, 24'h123400, 0, 0, 0, 0);
    runReq(0, 1, 2'd1, 24'h123402, 0, 0, 0, 0);
    // R5: programmed waits
    runReq(0, 0, 2'd0, 24'h055001, 3, 0, 0, 0);
    runReq(0, 1, 2'd2, 24'h055004, 15, 0, 0, 0);
    // R6: ready low beyond the count
    runReq(0, 0, 2'd1, 24'h066000, 0, 0, 4, 0);
    runReq(0, 1, 2'd0, 24'h066003, 2, 0, 6, 0);
    // R9: mirrored internal, still three clocks
    runReq(1, 0, 2'd2, 24'h000300, 7, 1, 5, 0);
    runReq(1, 1, 2'd1, 24'h000302, 0, 1, 0, 0);
    // R8: requests during busy
    runReq(0, 0, 2'd2, 24'h070000, 2, 0, 1, 1);
    runReq(1, 1, 2'd0, 24'h000011, 0, 1, 0, 1);

    // R10 R11 R7: random mix
    for (int n = 0; n < 400; n++) begin
      runReq(1'($urandom), 1'($urandom), 2'($urandom), AW'($urandom),
             int'($urandom_range(0, 5)), 1'($urandom),
             int'($urandom_range(0, 3)), 1'($urandom));
      if ($urandom_range(0, 3) == 0) @(negedge clk);
    end

    repeat (4) @(negedge clk);
    running = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule